// File: doc/BRIEF.md
# Ring-Buffered Remote DMA Data Port

This block is the host-facing data window of a small network controller's packet buffer. A host moves data through one port, one access at a time, at byte, word or dword width. Each access reads or writes the buffer at the current remote address. The block then moves that address forward by the access width and takes the same amount off a remaining-byte counter.

The address runs around a ring. The ring's lower and upper bounds are given as 256-byte page numbers. When the count lands on zero, a completion flag is raised in an interrupt status register, and the interrupt output follows that register through a mask.

Start address, byte count and ring pages are loaded from a configuration strobe. Frame transmit and receive sit outside this block. Each access runs through a three-state controller:
- `ST_IDLE` waits for a request. On a request (transition *accept*) it latches the access and goes to `ST_XFER`.
- `ST_XFER` touches the buffer, then goes to `ST_ADV` (transition *move*).
- `ST_ADV` pulses done, updates the address, count and status, and returns to `ST_IDLE` (transition *retire*).

Top module: `rdma_data_port`

## Requirements
- R1: After reset, dma_addr, dma_count, int_status, irq, acc_busy and acc_done are all zero, and every buffer byte reads as zero.
- R2: A request seen in ST_IDLE makes acc_busy high for the next two cycles. acc_done is high only in the second of them. acc_req is ignored while acc_busy is high.
- R3: acc_size encodes the width: 0 is byte (1), 1 is word (2), 2 or 3 is dword (4). Each performed access adds the width to dma_addr and subtracts it from dma_count, modulo 2^16.
- R4: If the advanced address equals the upper ring page times 256, dma_addr becomes the lower ring page times 256 instead.
- R5: An access that leaves dma_count at zero sets int_status bit 6. A pulse of isr_clr_we with a 1 in isr_clr_bits clears the matching status bits, and a set in the same cycle wins.
- R6: irq is high exactly when int_status AND int_mask is non-zero.
- R7: A write request while dma_count is zero still completes its handshake, but it changes neither the buffer, dma_addr, dma_count nor int_status.
- R8: The buffer location of a word access has address bit 0 cleared, and that of a dword access has bits 1:0 cleared. The advance starts from the unaligned address.
- R9: An access is valid when its aligned address is below 32, or is at least 256 and below 512. Invalid writes store nothing. Invalid reads return 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or dword, zero-extended to 32 bits.
- R10: Data is little-endian. acc_wdata byte i goes to, and acc_rdata byte i comes from, aligned address + i. acc_rdata bits above the access width are zero.
- R11: A cfg_we pulse loads dma_addr, dma_count and both ring pages in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load address, count and ring pages |
| cfg_addr | input | 16 | Start remote address |
| cfg_count | input | 16 | Remaining byte count |
| cfg_ring_lo | input | 8 | Ring lower page |
| cfg_ring_hi | input | 8 | Ring upper (stop) page |
| int_mask | input | 8 | Interrupt enable mask |
| isr_clr_we | input | 1 | Write-one-to-clear strobe for status |
| isr_clr_bits | input | 8 | Status bits to clear |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, valid from ST_ADV on |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | Access retiring this cycle |
| dma_addr | output | 16 | Current remote address |
| dma_count | output | 16 | Remaining byte count |
| int_status | output | 8 | Interrupt status register |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions assume that cfg_we never coincides with an access in flight. Otherwise a load and an advance would race for the same registers. The wrap check also assumes the two ring pages differ.

The stimulus keeps within these limits. It programs the registers only between accesses and holds every request for a single cycle, except in the one test that keeps acc_req high through a whole access on purpose. Ring pages are always chosen so that the upper page lies above the lower one.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } rdp_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_ADV  = 2'd2
    } rdp_state_e;

    // number of bytes an access of the given width moves
    function automatic logic [2:0] size_bytes(rdp_size_e s);
        unique case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/rdp_buffer.sv
module rdp_buffer
    import rdp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MEM_SIZE   = 512,
    parameter int LOW_WIN    = 32,
    parameter int PMEM_START = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  rdp_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int IDX_W = $clog2(MEM_SIZE);

    logic [7:0]        mem [MEM_SIZE];
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  base_idx;
    logic [2:0]        nbytes;
    logic              valid;
    logic [31:0]       rd_word;

    always_comb begin
        nbytes = size_bytes(size);
        unique case (size)
            SZ_BYTE: base = addr;
            SZ_WORD: base = {addr[ADDR_W-1:1], 1'b0};
            default: base = {addr[ADDR_W-1:2], 2'b00};
        endcase
        base_idx = base[IDX_W-1:0];
        valid = (base < ADDR_W'(LOW_WIN)) ||
                ((base >= ADDR_W'(PMEM_START)) && (base < ADDR_W'(MEM_SIZE)));
    end

    always_comb begin
        rd_word = '0;
        for (int j = 0; j < 4; j++) begin
            if (3'(j) < nbytes) begin
                rd_word[8*j +: 8] = valid ? mem[base_idx + IDX_W'(j)] : 8'hFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_SIZE; i++) mem[i] <= 8'h00;
            rdata <= '0;
        end else if (en) begin
            if (we) begin
                if (valid) begin
                    for (int j = 0; j < 4; j++) begin
                        if (3'(j) < nbytes) mem[base_idx + IDX_W'(j)] <= wdata[8*j +: 8];
                    end
                end
            end else begin
                rdata <= rd_word;
            end
        end
    end

    // R9: a read outside the windows returns ones in its lowest lane
    a_r9_invalid_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we && !valid) |=> (rdata[7:0] == 8'hFF));

endmodule

// File: rtl/rdp_ring_ctrl.sv
module rdp_ring_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PAGE_SHIFT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          ld_addr,
    input  logic [CNT_W-1:0]           ld_count,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] ld_lo,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] ld_hi,
    input  logic                       adv,
    input  logic [2:0]                 step,
    output logic [ADDR_W-1:0]          cur_addr,
    output logic [CNT_W-1:0]           remaining,
    output logic                       hit_zero
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [PAGE_W-1:0] lo_q, hi_q;
    logic [ADDR_W-1:0] stop_base, start_base, addr_inc, addr_nxt;
    logic [CNT_W-1:0]  step_c, cnt_nxt;

    always_comb begin
        stop_base  = {hi_q, {PAGE_SHIFT{1'b0}}};
        start_base = {lo_q, {PAGE_SHIFT{1'b0}}};
        addr_inc   = cur_addr + ADDR_W'(step);
        addr_nxt   = (addr_inc == stop_base) ? start_base : addr_inc;
        step_c     = CNT_W'(step);
        cnt_nxt    = remaining - step_c;
        hit_zero   = adv && !load && (cnt_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
        end else if (load) begin
            cur_addr  <= ld_addr;
            remaining <= ld_count;
            lo_q      <= ld_lo;
            hi_q      <= ld_hi;
        end else if (adv) begin
            cur_addr  <= addr_nxt;
            remaining <= cnt_nxt;
        end
    end

    // R3: the count drops by exactly one access width
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (remaining == $past(remaining) - $past(step_c)));

    // R4: after an advance the address never rests on the stop page boundary
    a_r4_off_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (lo_q != hi_q)) |=> (cur_addr != stop_base));

    // R11: a load takes effect on the next cycle
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((cur_addr == $past(ld_addr)) && (remaining == $past(ld_count))));

endmodule

// File: rtl/rdp_irq.sv
module rdp_irq #(
    parameter int ISR_W    = 8,
    parameter int DONE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_done,
    input  logic             clr_we,
    input  logic [ISR_W-1:0] clr_mask,
    input  logic [ISR_W-1:0] imr,
    output logic [ISR_W-1:0] isr,
    output logic             irq
);
    logic [ISR_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[DONE_BIT] = set_done;
        clr_vec = clr_we ? clr_mask : '0;
        irq = |(isr & imr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~clr_vec) | set_vec;
    end

    // R5: completion always leaves the flag set
    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> isr[DONE_BIT]);

    // R5: write-one-to-clear removes the flag when no set competes
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[DONE_BIT] && !set_done) |=> !isr[DONE_BIT]);

endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port
    import rdp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PAGE_SHIFT = 8,
    parameter int MEM_SIZE   = 512,
    parameter int LOW_WIN    = 32,
    parameter int PMEM_START = 256,
    parameter int ISR_W      = 8,
    parameter int DONE_BIT   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [CNT_W-1:0]             cfg_count,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_ring_lo,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_ring_hi,
    input  logic [ISR_W-1:0]             int_mask,
    input  logic                         isr_clr_we,
    input  logic [ISR_W-1:0]             isr_clr_bits,
    input  logic                         acc_req,
    input  logic                         acc_wr,
    input  logic [1:0]                   acc_size,
    input  logic [31:0]                  acc_wdata,
    output logic [31:0]                  acc_rdata,
    output logic                         acc_busy,
    output logic                         acc_done,
    output logic [ADDR_W-1:0]            dma_addr,
    output logic [CNT_W-1:0]             dma_count,
    output logic [ISR_W-1:0]             int_status,
    output logic                         irq
);
    rdp_state_e state_q, state_d;
    logic       wr_q, drop_q;
    rdp_size_e  size_q;
    logic [31:0] wdata_q;
    logic       buf_en, buf_we, adv, hit_zero;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, move, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_req) state_d = ST_XFER;
            ST_XFER: state_d = ST_ADV;
            ST_ADV:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // access capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            drop_q  <= 1'b0;
            size_q  <= SZ_BYTE;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && acc_req) begin
            wr_q    <= acc_wr;
            drop_q  <= acc_wr && (dma_count == '0);
            size_q  <= rdp_size_e'(acc_size);
            wdata_q <= acc_wdata;
        end
    end

    // state outputs
    always_comb begin
        acc_busy = (state_q != ST_IDLE);
        acc_done = (state_q == ST_ADV);
        buf_en   = (state_q == ST_XFER);
        buf_we   = wr_q && !drop_q;
        adv      = (state_q == ST_ADV) && !drop_q;
    end

    rdp_buffer #(
        .ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE),
        .LOW_WIN(LOW_WIN), .PMEM_START(PMEM_START)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .en(buf_en), .we(buf_we),
        .size(size_q), .addr(dma_addr), .wdata(wdata_q), .rdata(acc_rdata)
    );

    rdp_ring_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_ring (
        .clk(clk), .rst_n(rst_n), .load(cfg_we),
        .ld_addr(cfg_addr), .ld_count(cfg_count),
        .ld_lo(cfg_ring_lo), .ld_hi(cfg_ring_hi),
        .adv(adv), .step(size_bytes(size_q)),
        .cur_addr(dma_addr), .remaining(dma_count), .hit_zero(hit_zero)
    );

    rdp_irq #(.ISR_W(ISR_W), .DONE_BIT(DONE_BIT)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_done(hit_zero),
        .clr_we(isr_clr_we), .clr_mask(isr_clr_bits),
        .imr(int_mask), .isr(int_status), .irq(irq)
    );

    // R2: done is a single-cycle pulse
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    // R2: an idle request starts an access
    a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_busy && acc_req) |=> acc_busy);

    // R7: a dropped write leaves address and count alone
    a_r7_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && drop_q && !cfg_we) |=>
            ((dma_count == $past(dma_count)) && (dma_addr == $past(dma_addr))));

endmodule

// File: tb/sim_rdma_data_port.sv
`timescale 1ns/1ps
module sim_rdma_data_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_we = 0;
    logic [15:0] cfg_addr = 0, cfg_count = 0;
    logic [7:0]  cfg_ring_lo = 0, cfg_ring_hi = 0, int_mask = 0;
    logic        isr_clr_we = 0;
    logic [7:0]  isr_clr_bits = 0;
    logic        acc_req = 0, acc_wr = 0;
    logic [1:0]  acc_size = 0;
    logic [31:0] acc_wdata = 0;
    logic [31:0] acc_rdata;
    logic        acc_busy, acc_done, irq;
    logic [15:0] dma_addr, dma_count;
    logic [7:0]  int_status;

    rdma_data_port u0 (.*);

    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    bit settled = 0;

    // behavioural reference state
    byte unsigned m_mem [int];
    int m_addr, m_cnt, m_lo, m_hi, m_isr;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic byte unsigned mrd(int a);
        return m_mem.exists(a) ? m_mem[a] : 8'h00;
    endfunction

    // per-clock comparison of architectural state against the model
    always @(posedge clk) begin
        #15;
        if (rst_n && settled) begin
            check("R3 dma_addr", dma_addr, m_addr[15:0]);
            check("R3 dma_count", dma_count, m_cnt[15:0]);
            check("R5 int_status", int_status, m_isr[7:0]);
            check("R6 irq", irq, ((m_isr & int_mask) != 0));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cfg(int a, int c, int lo, int hi);
        settled = 0;
        @(negedge clk);
        cfg_we = 1; cfg_addr = a[15:0]; cfg_count = c[15:0];
        cfg_ring_lo = lo[7:0]; cfg_ring_hi = hi[7:0];
        @(negedge clk);
        cfg_we = 0;
        m_addr = a; m_cnt = c; m_lo = lo; m_hi = hi;
        settled = 1;
    endtask

    task automatic clr_isr(int bits);
        settled = 0;
        @(negedge clk);
        isr_clr_we = 1; isr_clr_bits = bits[7:0];
        @(negedge clk);
        isr_clr_we = 0;
        m_isr = m_isr & ~bits;
        settled = 1;
    endtask

    // model of one access; returns the expected read data
    function automatic logic [31:0] model(bit wr, int sz, logic [31:0] wd);
        int nb, base;
        bit ok;
        logic [31:0] r;
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        base = m_addr & ~(nb - 1);
        ok = (base < 32) || (base >= 256 && base < 512);
        r = 0;
        if (wr && m_cnt == 0) return 0;
        for (int i = 0; i < nb; i++) begin
            if (wr) begin
                if (ok) m_mem[base + i] = wd[8*i +: 8];
            end else begin
                r[8*i +: 8] = ok ? mrd(base + i) : 8'hFF;
            end
        end
        m_addr = (m_addr + nb) & 16'hFFFF;
        if (m_addr == (m_hi << 8)) m_addr = m_lo << 8;
        m_cnt = (m_cnt - nb) & 16'hFFFF;
        if (m_cnt == 0) m_isr = m_isr | 8'h40;
        return r;
    endfunction

    task automatic access(bit wr, int sz, logic [31:0] wd, string req);
        logic [31:0] exp;
        settled = 0;
        @(negedge clk);
        acc_req = 1; acc_wr = wr; acc_size = sz[1:0]; acc_wdata = wd;
        @(negedge clk);
        acc_req = 0;
        check("R2 busy in XFER", {acc_busy, acc_done}, 2'b10);
        @(negedge clk);
        check("R2 done in ADV", {acc_busy, acc_done}, 2'b11);
        @(negedge clk);
        check("R2 idle after retire", {acc_busy, acc_done}, 2'b00);
        exp = model(wr, sz, wd);
        if (!wr) check(req, acc_rdata, exp);
        settled = 1;
    endtask

    initial begin
        m_addr = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_isr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 addr", dma_addr, 0);
        check("R1 count", dma_count, 0);
        check("R1 status", {int_status, irq, acc_busy, acc_done}, 0);
        settled = 1;

        // R11 load, R1 buffer cleared
        cfg(16'h0100, 64, 1, 2);
        check("R11 loaded addr", dma_addr, 16'h0100);
        access(0, 2, 0, "R1 buffer zero after reset");
        cfg(16'h0100, 64, 1, 2);

        // R10 little-endian writes at byte, word and dword width
        access(1, 0, 32'h11, "R10");
        access(1, 0, 32'h22, "R10");
        access(1, 1, 32'h4433, "R10");
        access(1, 2, 32'h88776655, "R10");
        cfg(16'h0100, 64, 1, 2);
        access(0, 2, 0, "R10 dword read");
        access(0, 1, 0, "R10 word read");
        access(0, 0, 0, "R10 byte read");
        access(0, 3, 0, "R3 code 3 as dword");

        // R8 unaligned word and dword
        cfg(16'h0103, 64, 1, 2);
        access(1, 1, 32'hBEEF, "R8");
        check("R8 advance from unaligned", dma_addr, 16'h0105);
        cfg(16'h0101, 64, 1, 2);
        access(0, 2, 0, "R8 dword aligned read");

        // R9 invalid window reads and writes; low window valid
        cfg(16'h0040, 64, 1, 2);
        access(0, 0, 0, "R9 byte ones");
        access(0, 1, 0, "R9 word ones");
        access(0, 2, 0, "R9 dword ones");
        access(1, 2, 32'h12345678, "R9");
        cfg(16'h0010, 64, 1, 2);
        access(1, 2, 32'hCAFEF00D, "R9");
        cfg(16'h0010, 64, 1, 2);
        access(0, 2, 0, "R9 low window");
        cfg(16'h01FC, 64, 1, 3);
        access(1, 2, 32'hA5A5A5A5, "R9");
        cfg(16'h0200, 64, 1, 3);
        access(0, 2, 0, "R9 above buffer ones");

        // R4 wrap on the stop page
        cfg(16'h01FE, 16, 1, 2);
        access(1, 1, 32'h7E7E, "R4");
        check("R4 wrapped addr", dma_addr, 16'h0100);

        // R5, R6 completion flag and mask
        int_mask = 8'h00;
        cfg(16'h0120, 3, 1, 2);
        access(0, 1, 0, "R5 partial");
        check("R5 not yet", int_status, 0);
        access(0, 0, 0, "R5 final byte");
        check("R5 flag set", int_status, 8'h40);
        check("R6 masked off", irq, 0);
        @(negedge clk); int_mask = 8'h40;
        @(negedge clk);
        check("R6 enabled", irq, 1);

        // R7 write at zero count ignored
        access(1, 2, 32'hDEADBEEF, "R7");
        check("R7 count held", dma_count, 0);
        check("R7 addr held", dma_addr, 16'h0123);
        cfg(16'h0120, 8, 1, 2);
        access(0, 2, 0, "R7 buffer unchanged");

        clr_isr(8'h40);
        check("R5 cleared", int_status, 0);
        check("R6 low after clear", irq, 0);

        // R2 request held high while busy: one access only
        cfg(16'h0130, 20, 1, 2);
        settled = 0;
        @(negedge clk);
        acc_req = 1; acc_wr = 1; acc_size = 0; acc_wdata = 32'h5A;
        repeat (3) @(negedge clk);
        acc_req = 0;
        void'(model(1, 0, 32'h5A));
        check("R2 single advance", dma_count, 19);
        settled = 1;

        // R3 count wraps below zero on reads
        cfg(16'h0140, 1, 1, 2);
        access(0, 1, 0, "R3 read");
        check("R3 count modulo", dma_count, 16'hFFFF);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule